// File: doc/BRIEF.md
# Transmit queue priority scheduler

This block decides which of up to sixteen transmit queues sends its next frame descriptor, and to which of eight prioritized output channels that descriptor goes. Configuration writes give each queue its channel, an active flag, an operating mode (scheduler-ack or in-order FIFO), a window size and a frame limit. Producers post descriptors to a queue, which raises its pending count. Downstream logic reports finished frames, which lowers the queue's outstanding count.

Channel 7 carries commands. Channels 3, 2, 1 and 0 carry voice/management, video, best-effort and background data, in falling priority. Channels 4 to 6 are normally left unmapped, but they still rank by number. The scheduler takes the highest-numbered channel that has an eligible queue. Within that channel it serves queues round-robin, starting after the queue that channel last granted. The choice goes out on a valid/ready port as a queue index plus a channel number.

The control is a two-state machine:
- ST_ARB evaluates eligibility every cycle. Transition ARB_TO_OFFER fires as soon as any queue is eligible, and the winner is latched on that edge.
- ST_OFFER holds the latched grant. Transition OFFER_TO_ARB fires on the handshake. Transition OFFER_HOLD keeps the grant while the consumer is not ready.

Top module: `txq_sched`

## Requirements
- R1: After reset no grant is offered (gnt_valid is 0). Every queue starts inactive, on channel 0, in scheduler-ack mode, with window size and frame limit both set to 64.
- R2: A queue is eligible only when all three of these hold: it is active, its pending count is nonzero, and its outstanding count is below its cap. Posting to an inactive queue produces no grant.
- R3: When several channels hold eligible queues, the grant goes to the highest channel number. Channel 7, the command channel, therefore wins over all data channels. gnt_ch reports the channel the queue was mapped to when it was selected.
- R4: Within one channel, eligible queues are granted round-robin in ascending index order with wrap-around. The search starts just after the queue that channel last granted.
- R5: A grant holds gnt_valid, gnt_q and gnt_ch stable until gnt_ready is seen. The handshake moves one descriptor from pending to outstanding. gnt_valid is low in the cycle after a handshake.
- R6: In scheduler-ack mode, a queue's cap on outstanding frames is the smaller of its window size and its frame limit.
- R7: In FIFO mode, a queue's cap is 1. A queue mapped to channel 7 is always treated as FIFO mode, whatever its mode bit says.
- R8: A configuration write during an offered grant does not change that grant. Remap and deactivation take effect at the next arbitration.
- R9: A completion reported for a queue with zero outstanding frames is ignored. The outstanding count stays at 0, so the queue can still be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the configuration of queue cfg_q |
| cfg_q | input | 4 | Queue being configured |
| cfg_ch | input | 3 | Output channel for the queue (7 = command) |
| cfg_active | input | 1 | Queue active flag |
| cfg_fifo | input | 1 | 1 = in-order FIFO mode, 0 = scheduler-ack mode |
| cfg_win | input | 7 | Window size |
| cfg_limit | input | 7 | Frame limit |
| push_vld | input | 1 | Post one descriptor to queue push_q |
| push_q | input | 4 | Queue receiving the descriptor |
| cmpl_vld | input | 1 | One frame of queue cmpl_q finished |
| cmpl_q | input | 4 | Queue whose frame finished |
| gnt_valid | output | 1 | A grant is offered |
| gnt_ready | input | 1 | Consumer accepts the offered grant |
| gnt_q | output | 4 | Granted queue |
| gnt_ch | output | 3 | Channel of the granted queue |

## Verification
A corrupted pending or outstanding counter shows at the ports within two cycles of the stimulus that should make a queue eligible: either a grant appears for a queue that should be capped or inactive, or an expected grant never arrives. A wrong round-robin pointer shows as a queue index out of order on the first grant after a channel's previous handshake. A wrong channel choice shows on the very next grant offered once two channels hold work. A corrupted state machine shows as a grant whose index changes while it is held, or as back-to-back grants without the one-cycle gap.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;
    localparam int CH_W   = 3;
    localparam int NUM_CH = 1 << CH_W;
    localparam int LIM_W  = 7;
    localparam logic [CH_W-1:0]  CMD_CH   = CH_W'(NUM_CH - 1);
    localparam logic [LIM_W-1:0] LIM_DFLT = LIM_W'(64);

    typedef enum logic {
        ST_ARB,
        ST_OFFER
    } sched_state_e;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic             active;
        logic             fifo_mode;
        logic [LIM_W-1:0] win;
        logic [LIM_W-1:0] limit;
    } q_cfg_t;
endpackage

// File: rtl/txq_ctx_bank.sv
module txq_ctx_bank
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int CNT_W = 8,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [QW-1:0]                    cfg_q,
    input  q_cfg_t                           cfg_data,
    input  logic                             push_vld,
    input  logic [QW-1:0]                    push_q,
    input  logic                             cmpl_vld,
    input  logic [QW-1:0]                    cmpl_q,
    input  logic                             take_vld,
    input  logic [QW-1:0]                    take_q,
    output logic [NUM_Q-1:0]                 elig,
    output logic [NUM_Q-1:0][CH_W-1:0]       ch_map,
    output logic [NUM_Q-1:0][CNT_W-1:0]      pend_cnt,
    output logic [NUM_Q-1:0][LIM_W-1:0]      out_cnt
);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        q_cfg_t           cfg_r;
        logic [CNT_W-1:0] pend_r;
        logic [LIM_W-1:0] out_r;
        logic [LIM_W-1:0] cap;
        logic             push_hit;
        logic             take_hit;
        logic             cmpl_hit;

        assign push_hit = push_vld && (push_q == QW'(g)) && (pend_r != '1);
        assign take_hit = take_vld && (take_q == QW'(g));
        assign cmpl_hit = cmpl_vld && (cmpl_q == QW'(g)) && (out_r != '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_r  <= '{ch: '0, active: 1'b0, fifo_mode: 1'b0,
                            win: LIM_DFLT, limit: LIM_DFLT};
                pend_r <= '0;
                out_r  <= '0;
            end else begin
                if (cfg_we && (cfg_q == QW'(g))) begin
                    cfg_r <= cfg_data;
                end
                pend_r <= pend_r + CNT_W'(push_hit) - CNT_W'(take_hit);
                out_r  <= out_r + LIM_W'(take_hit) - LIM_W'(cmpl_hit);
            end
        end

        // command channel is forced to in-order service
        always_comb begin
            if (cfg_r.fifo_mode || (cfg_r.ch == CMD_CH)) begin
                cap = LIM_W'(1);
            end else if (cfg_r.win < cfg_r.limit) begin
                cap = cfg_r.win;
            end else begin
                cap = cfg_r.limit;
            end
        end

        assign elig[g]     = cfg_r.active && (pend_r != '0) && (out_r < cap);
        assign ch_map[g]   = cfg_r.ch;
        assign pend_cnt[g] = pend_r;
        assign out_cnt[g]  = out_r;
    end

endmodule

// File: rtl/txq_ch_arb.sv
module txq_ch_arb
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q = 16,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_Q-1:0]           elig,
    input  logic [NUM_Q-1:0][CH_W-1:0] ch_map,
    input  logic                       upd,
    input  logic [QW-1:0]              upd_q,
    input  logic [CH_W-1:0]            upd_ch,
    output logic                       any,
    output logic [QW-1:0]              win_q,
    output logic [CH_W-1:0]            win_ch
);

    logic [NUM_CH-1:0][NUM_Q-1:0] mask;
    logic [NUM_CH-1:0]            ch_busy;
    logic [NUM_CH-1:0][QW-1:0]    last_r;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar q = 0; q < NUM_Q; q++) begin : g_m
            assign mask[c][q] = elig[q] && (ch_map[q] == CH_W'(c));
        end
        assign ch_busy[c] = |mask[c];
    end

    assign any = |ch_busy;

    // ascending scan: the highest busy channel is the last to assign
    always_comb begin
        win_ch = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_busy[c]) begin
                win_ch = CH_W'(c);
            end
        end
    end

    always_comb begin
        logic found;
        found = 1'b0;
        win_q = '0;
        for (int i = 1; i <= NUM_Q; i++) begin
            int k;
            k = (int'(last_r[win_ch]) + i) % NUM_Q;
            if (!found && mask[win_ch][k]) begin
                win_q = QW'(k);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                last_r[c] <= QW'(NUM_Q - 1);
            end
        end else if (upd) begin
            last_r[upd_ch] <= upd_q;
        end
    end

endmodule

// File: rtl/txq_sched.sv
module txq_sched
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int CNT_W = 8,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [QW-1:0]    cfg_q,
    input  logic [CH_W-1:0]  cfg_ch,
    input  logic             cfg_active,
    input  logic             cfg_fifo,
    input  logic [LIM_W-1:0] cfg_win,
    input  logic [LIM_W-1:0] cfg_limit,
    input  logic             push_vld,
    input  logic [QW-1:0]    push_q,
    input  logic             cmpl_vld,
    input  logic [QW-1:0]    cmpl_q,
    output logic             gnt_valid,
    input  logic             gnt_ready,
    output logic [QW-1:0]    gnt_q,
    output logic [CH_W-1:0]  gnt_ch
);

    sched_state_e                state_r;
    sched_state_e                state_nx;
    logic [QW-1:0]               sel_q_r;
    logic [CH_W-1:0]             sel_ch_r;
    logic                        take;
    logic                        any;
    logic [QW-1:0]               win_q;
    logic [CH_W-1:0]             win_ch;
    logic [NUM_Q-1:0]            elig;
    logic [NUM_Q-1:0][CH_W-1:0]  ch_map;
    logic [NUM_Q-1:0][CNT_W-1:0] pend_cnt;
    logic [NUM_Q-1:0][LIM_W-1:0] out_cnt;
    q_cfg_t                      cfg_data;

    assign cfg_data = '{ch: cfg_ch, active: cfg_active, fifo_mode: cfg_fifo,
                        win: cfg_win, limit: cfg_limit};

    txq_ctx_bank #(.NUM_Q(NUM_Q), .CNT_W(CNT_W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_q    (cfg_q),
        .cfg_data (cfg_data),
        .push_vld (push_vld),
        .push_q   (push_q),
        .cmpl_vld (cmpl_vld),
        .cmpl_q   (cmpl_q),
        .take_vld (take),
        .take_q   (sel_q_r),
        .elig     (elig),
        .ch_map   (ch_map),
        .pend_cnt (pend_cnt),
        .out_cnt  (out_cnt)
    );

    txq_ch_arb #(.NUM_Q(NUM_Q)) i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig   (elig),
        .ch_map (ch_map),
        .upd    (take),
        .upd_q  (sel_q_r),
        .upd_ch (sel_ch_r),
        .any    (any),
        .win_q  (win_q),
        .win_ch (win_ch)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_r <= ST_ARB;
        end else begin
            state_r <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            ST_ARB:   state_nx = any ? ST_OFFER : ST_ARB;     // ARB_TO_OFFER
            ST_OFFER: state_nx = gnt_ready ? ST_ARB : ST_OFFER; // OFFER_TO_ARB / OFFER_HOLD
            default:  state_nx = ST_ARB;
        endcase
    end

    // winner latch: taken only on ARB_TO_OFFER, so config writes never reach a held grant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q_r  <= '0;
            sel_ch_r <= '0;
        end else if ((state_r == ST_ARB) && any) begin
            sel_q_r  <= win_q;
            sel_ch_r <= win_ch;
        end
    end

    // outputs
    always_comb begin
        gnt_valid = (state_r == ST_OFFER);
        gnt_q     = sel_q_r;
        gnt_ch    = sel_ch_r;
        take      = (state_r == ST_OFFER) && gnt_ready;
    end

endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int CNT_W = 8,
    localparam int QW   = $clog2(NUM_Q)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        gnt_valid,
    input logic                        gnt_ready,
    input logic [QW-1:0]               gnt_q,
    input logic [CH_W-1:0]             gnt_ch,
    input logic [NUM_Q-1:0][CNT_W-1:0] pend_cnt,
    input logic [NUM_Q-1:0][LIM_W-1:0] out_cnt,
    input logic [NUM_Q-1:0][CH_W-1:0]  ch_map
);

    logic [NUM_Q-1:0][CH_W-1:0] map_d;

    always_ff @(posedge clk) begin
        map_d <= ch_map;
    end

    AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_q) && $stable(gnt_ch)); // R5

    AST_GNT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid && gnt_ready |=> !gnt_valid); // R5

    AST_GNT_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> pend_cnt[gnt_q] != '0); // R2

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid && (gnt_ch == CMD_CH) |-> out_cnt[gnt_q] == '0); // R7

    AST_CH_OF_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> gnt_ch == map_d[gnt_q]); // R3

endmodule

bind txq_sched txq_sched_chk #(.NUM_Q(NUM_Q), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_valid (gnt_valid),
    .gnt_ready (gnt_ready),
    .gnt_q     (gnt_q),
    .gnt_ch    (gnt_ch),
    .pend_cnt  (pend_cnt),
    .out_cnt   (out_cnt),
    .ch_map    (ch_map)
);

// File: tb/test_txq_sched.sv
`timescale 1ns/1ps
module test_txq_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_q = '0;
    logic [2:0] cfg_ch = '0;
    logic       cfg_active = 1'b0;
    logic       cfg_fifo = 1'b0;
    logic [6:0] cfg_win = 7'd64;
    logic [6:0] cfg_limit = 7'd64;
    logic       push_vld = 1'b0;
    logic [3:0] push_q = '0;
    logic       cmpl_vld = 1'b0;
    logic [3:0] cmpl_q = '0;
    logic       gnt_valid;
    logic       gnt_ready = 1'b0;
    logic [3:0] gnt_q;
    logic [2:0] gnt_ch;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    txq_sched i_txq_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_q(cfg_q), .cfg_ch(cfg_ch),
        .cfg_active(cfg_active), .cfg_fifo(cfg_fifo), .cfg_win(cfg_win),
        .cfg_limit(cfg_limit), .push_vld(push_vld), .push_q(push_q),
        .cmpl_vld(cmpl_vld), .cmpl_q(cmpl_q), .gnt_valid(gnt_valid),
        .gnt_ready(gnt_ready), .gnt_q(gnt_q), .gnt_ch(gnt_ch)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int q, input int ch, input bit act, input bit fifo,
                       input int win, input int lim);
        cfg_q = 4'(q); cfg_ch = 3'(ch); cfg_active = act; cfg_fifo = fifo;
        cfg_win = 7'(win); cfg_limit = 7'(lim); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input int q);
        push_q = 4'(q); push_vld = 1'b1;
        @(negedge clk);
        push_vld = 1'b0;
    endtask

    task automatic cmpl(input int q);
        cmpl_q = 4'(q); cmpl_vld = 1'b1;
        @(negedge clk);
        cmpl_vld = 1'b0;
    endtask

    task automatic wait_valid();
        for (int n = 0; n < 10 && !gnt_valid; n++) @(negedge clk);
    endtask

    // accept one grant and check it, plus the gap after the handshake
    task automatic take(input int q, input int ch, input string tag);
        wait_valid();
        chk(gnt_valid == 1'b1, {tag, " valid"}, int'(gnt_valid), 1);
        chk(gnt_q == 4'(q), {tag, " queue"}, int'(gnt_q), q);
        chk(gnt_ch == 3'(ch), {tag, " channel"}, int'(gnt_ch), ch);
        gnt_ready = 1'b1;
        @(negedge clk);
        gnt_ready = 1'b0;
        chk(gnt_valid == 1'b0, "R5 gap after handshake", int'(gnt_valid), 0);
    endtask

    task automatic no_grant(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(gnt_valid == 1'b0, tag, int'(gnt_valid), 0);
        end
    endtask

    // queue 15 on channel 0 holds an offered grant as a blocker
    task automatic block_on();
        push(15);
        wait_valid();
        chk(gnt_valid && gnt_q == 4'd15, "blocker offered", int'(gnt_q), 15);
    endtask

    task automatic block_off();
        take(15, 0, "blocker");
        cmpl(15);
    endtask

    task automatic t_reset();
        chk(gnt_valid == 1'b0, "R1 reset no grant", int'(gnt_valid), 0);
        push(0);
        no_grant(6, "R2 inactive queue not granted");
        cfg(0, 0, 1, 0, 64, 64);
        take(0, 0, "R2 activated queue");
        cfg(15, 0, 1, 1, 64, 64);
    endtask

    task automatic t_priority();
        cfg(12, 0, 1, 0, 64, 64);
        cfg(1, 1, 1, 0, 64, 64);
        cfg(2, 3, 1, 0, 64, 64);
        cfg(3, 7, 1, 1, 64, 64);
        block_on();
        push(12); push(1); push(2); push(3);
        chk(gnt_valid && gnt_q == 4'd15, "R5 held grant stable", int'(gnt_q), 15);
        block_off();
        take(3, 7, "R3 command first");
        take(2, 3, "R3 voice next");
        take(1, 1, "R3 best effort next");
        take(12, 0, "R3 background last");
        cmpl(3);
    endtask

    task automatic t_rr();
        cfg(4, 1, 1, 0, 64, 64);
        cfg(6, 1, 1, 0, 64, 64);
        cfg(9, 1, 1, 0, 64, 64);
        block_on();
        push(9); push(6); push(4); push(9); push(6); push(4);
        block_off();
        take(4, 1, "R4 rr first");
        take(6, 1, "R4 rr second");
        take(9, 1, "R4 rr third");
        take(4, 1, "R4 rr wrap");
        take(6, 1, "R4 rr fifth");
        take(9, 1, "R4 rr sixth");
    endtask

    task automatic t_cap();
        cfg(7, 2, 1, 0, 2, 5);
        push(7); push(7); push(7); push(7);
        take(7, 2, "R6 win cap 1");
        take(7, 2, "R6 win cap 2");
        no_grant(6, "R6 window size caps");
        cmpl(7);
        take(7, 2, "R6 after completion");
        cfg(8, 2, 1, 0, 7, 1);
        push(8); push(8);
        take(8, 2, "R6 limit cap 1");
        no_grant(6, "R6 frame limit caps");
        cmpl(8);
        take(8, 2, "R6 limit after completion");
        cmpl(8);
        cmpl(7);
        take(7, 2, "R6 drain");
    endtask

    task automatic t_fifo();
        cfg(10, 7, 1, 0, 64, 64);
        push(10); push(10);
        take(10, 7, "R7 command forced fifo 1");
        no_grant(6, "R7 command one outstanding");
        cmpl(10);
        take(10, 7, "R7 command forced fifo 2");
        cmpl(10);
        cfg(11, 3, 1, 1, 64, 64);
        push(11); push(11);
        take(11, 3, "R7 fifo mode 1");
        no_grant(6, "R7 fifo one outstanding");
        cmpl(11);
        take(11, 3, "R7 fifo mode 2");
        cmpl(11);
    endtask

    task automatic t_cfg();
        cfg(5, 2, 1, 0, 64, 64);
        push(5);
        push(5);
        wait_valid();
        cfg(5, 2, 0, 0, 64, 64);
        chk(gnt_valid && gnt_q == 4'd5, "R8 offer survives deactivate", int'(gnt_q), 5);
        take(5, 2, "R8 offered grant completes");
        no_grant(6, "R8 deactivation at next arbitration");
        cfg(5, 4, 1, 0, 64, 64);
        take(5, 4, "R8 remap takes effect");
    endtask

    task automatic t_cmpl();
        cfg(13, 1, 1, 1, 64, 64);
        cmpl(13);
        push(13);
        take(13, 1, "R9 stray completion ignored");
        cmpl(13);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_priority();
                t_rr();
                t_cap();
                t_fifo();
                t_cfg();
                t_cmpl();
            end
            begin
                repeat (20000) @(negedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule